// File: doc/BRIEF.md
# CAN Fault Confinement Error Counters

This block keeps the transmit error count (TEC) and receive error count (REC) of a CAN node and derives the node's fault-confinement state from them. It takes its inputs from the bit-level protocol engine as single-cycle strobes. These strobes report detected errors together with the node's role and the error's circumstances, the serial bits seen while dominant runs are tracked, successful transmission or reception, and the start of the error delimiter.

Increments are not applied when the error is reported. They collect in a pending register for each counter and are committed together on the delimiter-start strobe. Every decision taken while the error is being signalled therefore sees the counter values from before the error. Decrements for an error-free frame apply at once. The receive counter is 7 bits wide, and a separate receive-passive bit marks an overflow beyond 127. The first successful reception after an overflow reloads REC to a fixed value instead of decrementing it. Bus-off freezes everything until reset.

Top module: `can_fc_counters`

## Requirements
- R1: After reset, TEC = 0, REC = 0, rec_passive = 0, err_active = 1, err_passive = 0, bus_off = 0 and overload_req = 0.
- R2: A receiver error strobe adds 1 to REC. A dominant-after-flag strobe adds 8 to REC. Neither changes TEC.
- R3: A transmitter error-flag strobe adds 8 to TEC, with two exceptions that add nothing. The first is an ACK error while the node is error-passive and no dominant bit was seen during its passive flag. The second is a stuff error in arbitration where the recessive stuff bit was read back dominant.
- R4: A bit error while the node sends an active error or overload flag adds 8 to TEC when node_is_tx = 1, and to REC otherwise.
- R5: After a flag-start strobe, consecutive dominant bits are counted. The first threshold is 14 when flag_passive = 0 and 8 when flag_passive = 1. Each further 8 dominant bits is another threshold, and each threshold reached adds 8 to the role latched at flag start (TEC if transmitter). A recessive bit or the delimiter strobe ends the tracking.
- R6: Pending increments do not change TEC or REC before delim_start. They are committed in the cycle of delim_start and are visible on the outputs one cycle later.
- R7: ev_tx_ok decrements TEC by 1, and leaves TEC at 0 when it is already 0.
- R8: ev_rx_ok decrements REC by 1 when REC is in 1..127 and leaves it at 0 when it is 0. When rec_passive = 1, ev_rx_ok loads REC with 127 and clears rec_passive.
- R9: When a commit would take REC above 127, REC holds 127 and rec_passive is set. While rec_passive = 1, REC increments are discarded.
- R10: err_passive = 1 when TEC > 127 or rec_passive = 1 and the node is not bus-off. err_active = 1 otherwise. Exactly one of err_active, err_passive and bus_off is high.
- R11: When a commit would take TEC above 255, bus_off is set and TEC reads 255. From then until reset, TEC and REC are frozen and every event strobe is ignored, overload requests included.
- R12: A bit error in intermission (intermission_err) raises overload_req for exactly one cycle, in the following cycle, and changes no counter.
- R13: When delim_start and ev_tx_ok are high in the same cycle, the commit takes place and the decrement is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_rx_err | input | 1 | Error detected as receiver (+1 REC) |
| ev_rx_dom_after | input | 1 | Dominant bit seen right after own error flag (+8 REC) |
| ev_tx_err_flag | input | 1 | Transmitter sends an error flag (+8 TEC unless exempt) |
| tx_err_ack | input | 1 | Qualifier: the transmitter error is an ACK error |
| tx_pflag_dom_seen | input | 1 | Qualifier: dominant bit seen during the passive error flag |
| tx_err_stuff_arb | input | 1 | Qualifier: stuff error on a recessive stuff bit in arbitration |
| ev_flag_bit_err | input | 1 | Bit error during own active error or overload flag |
| node_is_tx | input | 1 | Node role: 1 transmitter, 0 receiver |
| flag_start | input | 1 | Start of dominant-run tracking |
| flag_passive | input | 1 | Tracking follows a passive flag (8-bit first threshold) |
| bit_strobe | input | 1 | One bit time has been sampled |
| bit_dom | input | 1 | Sampled bit is dominant |
| ev_tx_ok | input | 1 | Frame transmitted without error |
| ev_rx_ok | input | 1 | Frame received without error |
| delim_start | input | 1 | First bit of the error delimiter; commits increments |
| intermission_err | input | 1 | Bit error detected during intermission |
| tec | output | 8 | Transmit error counter |
| rec | output | 7 | Receive error counter |
| rec_passive | output | 1 | REC overflowed beyond 127 |
| err_active | output | 1 | Node is error-active |
| err_passive | output | 1 | Node is error-passive |
| bus_off | output | 1 | Node is bus-off |
| overload_req | output | 1 | One-cycle request for an overload frame |

## Verification
The bench uses the default parameters: an 8-bit TEC, a 7-bit REC, dominant-run thresholds of 14 and 8, and a reload value of 127. With these widths a few dozen commits take TEC past the passive limit and on into bus-off, and take REC into overflow. The passive-dependent ACK exception, the reload path and the bus-off freeze are therefore all reached in a short run. Runs of 13 dominant bits, and runs stretching past the 14-bit threshold into the 8-bit follow-on threshold, exercise both run counter limits.

// File: rtl/can_fc_pkg.sv
// Package: shared constants and helpers for the fault-confinement counters.
// Assumes: nothing beyond standard integer arithmetic at elaboration.
package can_fc_pkg;

    localparam int FC_LANE_TX = 0;
    localparam int FC_LANE_RX = 1;
    localparam int FC_LANES   = 2;

    // Larger of two elaboration-time integers.
    function automatic int fc_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/can_fc_domrun.sv
// Module: tracks consecutive dominant bits after a flag start and pulses
// once per threshold reached (first threshold 14 or 8, then every 8).
// Assumes: bit_strobe is high for one cycle per bit time; flag_start and
// stop have priority over the bit in the same cycle.
module can_fc_domrun #(
    parameter int ACTIVE_RUN  = 14,
    parameter int PASSIVE_RUN = 8,
    parameter int STEP_RUN    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_start,
    input  logic flag_passive,
    input  logic role_tx,
    input  logic bit_strobe,
    input  logic bit_dom,
    input  logic stop,
    output logic run_hit,
    output logic run_tx
);
    import can_fc_pkg::*;

    localparam int RUN_MAX = fc_max(ACTIVE_RUN, fc_max(PASSIVE_RUN, STEP_RUN));
    localparam int CW      = $clog2(RUN_MAX + 1);

    logic          armed_q;
    logic          tx_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] thr_q;
    logic [CW-1:0] cnt_inc;
    logic          take_bit;

    // Qualify a tracked dominant bit and detect the threshold.
    always_comb begin
        cnt_inc  = cnt_q + CW'(1);
        take_bit = armed_q && bit_strobe && !flag_start && !stop;
        run_hit  = take_bit && bit_dom && (cnt_inc == thr_q);
    end

    assign run_tx = tx_q;

    // Arm, count, rearm on threshold, disarm on recessive or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            tx_q    <= 1'b0;
            cnt_q   <= '0;
            thr_q   <= CW'(ACTIVE_RUN);
        end else if (flag_start) begin
            armed_q <= 1'b1;
            tx_q    <= role_tx;
            cnt_q   <= '0;
            thr_q   <= flag_passive ? CW'(PASSIVE_RUN) : CW'(ACTIVE_RUN);
        end else if (stop) begin
            armed_q <= 1'b0;
        end else if (take_bit) begin
            if (!bit_dom) begin
                armed_q <= 1'b0;
            end else if (run_hit) begin
                cnt_q <= '0;
                thr_q <= CW'(STEP_RUN);
            end else begin
                cnt_q <= cnt_inc;
            end
        end
    end

endmodule

// File: rtl/can_fc_inc_decode.sv
// Module: turns one cycle of event strobes into the increments owed to
// TEC and REC, applying the two transmitter exemptions.
// Assumes: passive_now reflects counters from before the current error.
module can_fc_inc_decode #(
    parameter int PEND_W   = 10,
    parameter int BIG_STEP = 8
) (
    input  logic              ev_rx_err,
    input  logic              ev_rx_dom_after,
    input  logic              ev_tx_err_flag,
    input  logic              tx_err_ack,
    input  logic              tx_pflag_dom_seen,
    input  logic              tx_err_stuff_arb,
    input  logic              ev_flag_bit_err,
    input  logic              node_is_tx,
    input  logic              passive_now,
    input  logic              run_hit,
    input  logic              run_tx,
    output logic [PEND_W-1:0] tx_inc,
    output logic [PEND_W-1:0] rx_inc
);
    logic tx_exempt;

    // Sum the per-cycle increments for each counter.
    always_comb begin
        tx_exempt = (tx_err_ack && passive_now && !tx_pflag_dom_seen) || tx_err_stuff_arb;
        tx_inc    = '0;
        rx_inc    = '0;
        if (ev_tx_err_flag && !tx_exempt) tx_inc = tx_inc + PEND_W'(BIG_STEP);
        if (ev_flag_bit_err && node_is_tx) tx_inc = tx_inc + PEND_W'(BIG_STEP);
        if (ev_flag_bit_err && !node_is_tx) rx_inc = rx_inc + PEND_W'(BIG_STEP);
        if (run_hit && run_tx)  tx_inc = tx_inc + PEND_W'(BIG_STEP);
        if (run_hit && !run_tx) rx_inc = rx_inc + PEND_W'(BIG_STEP);
        if (ev_rx_err)          rx_inc = rx_inc + PEND_W'(1);
        if (ev_rx_dom_after)    rx_inc = rx_inc + PEND_W'(BIG_STEP);
    end

endmodule

// File: rtl/can_fc_accum.sv
// Module: one pending-increment register with saturating add. On commit
// the old value is handed over and only this cycle's increment is kept.
// Assumes: freeze (bus-off) discards everything.
module can_fc_accum #(
    parameter int PEND_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              freeze,
    input  logic [PEND_W-1:0] add,
    output logic [PEND_W-1:0] pend
);
    logic [PEND_W:0] sum;

    // Saturating sum of held and new increments.
    always_comb sum = {1'b0, pend} + {1'b0, add};

    // Hold, restart on commit, clear on freeze.
    always_ff @(posedge clk) begin
        if (!rst_n || freeze) begin
            pend <= '0;
        end else if (commit) begin
            pend <= add;
        end else begin
            pend <= sum[PEND_W] ? '1 : sum[PEND_W-1:0];
        end
    end

endmodule

// File: rtl/can_fc_counters.sv
// Module: top of the fault-confinement counters. Holds TEC, REC and the
// receive-passive bit, commits pending increments on delimiter start,
// applies success decrements, and derives active/passive/bus-off.
// Assumes: strobes are single-cycle and synchronous to clk.
module can_fc_counters #(
    parameter int TEC_W       = 8,
    parameter int REC_W       = 7,
    parameter int PEND_W      = 10,
    parameter int BIG_STEP    = 8,
    parameter int ACTIVE_RUN  = 14,
    parameter int PASSIVE_RUN = 8,
    parameter int STEP_RUN    = 8,
    parameter int REC_RELOAD  = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_rx_err,
    input  logic             ev_rx_dom_after,
    input  logic             ev_tx_err_flag,
    input  logic             tx_err_ack,
    input  logic             tx_pflag_dom_seen,
    input  logic             tx_err_stuff_arb,
    input  logic             ev_flag_bit_err,
    input  logic             node_is_tx,
    input  logic             flag_start,
    input  logic             flag_passive,
    input  logic             bit_strobe,
    input  logic             bit_dom,
    input  logic             ev_tx_ok,
    input  logic             ev_rx_ok,
    input  logic             delim_start,
    input  logic             intermission_err,
    output logic [TEC_W-1:0] tec,
    output logic [REC_W-1:0] rec,
    output logic             rec_passive,
    output logic             err_active,
    output logic             err_passive,
    output logic             bus_off,
    output logic             overload_req
);
    import can_fc_pkg::*;

    localparam int TEC_MAX = (1 << TEC_W) - 1;
    localparam int REC_MAX = (1 << REC_W) - 1;
    localparam int SUM_W   = fc_max(fc_max(TEC_W, REC_W), PEND_W) + 1;

    logic              run_hit;
    logic              run_tx;
    logic              passive_now;
    logic [PEND_W-1:0] lane_add  [FC_LANES];
    logic [PEND_W-1:0] lane_pend [FC_LANES];
    logic [SUM_W-1:0]  tec_sum;
    logic [SUM_W-1:0]  rec_sum;

    // Passive condition from the pre-error counter values.
    assign passive_now = (tec > TEC_W'(REC_MAX)) || rec_passive;

    can_fc_domrun #(
        .ACTIVE_RUN (ACTIVE_RUN),
        .PASSIVE_RUN(PASSIVE_RUN),
        .STEP_RUN   (STEP_RUN)
    ) u_run (
        .clk         (clk),
        .rst_n       (rst_n),
        .flag_start  (flag_start),
        .flag_passive(flag_passive),
        .role_tx     (node_is_tx),
        .bit_strobe  (bit_strobe),
        .bit_dom     (bit_dom),
        .stop        (delim_start),
        .run_hit     (run_hit),
        .run_tx      (run_tx)
    );

    can_fc_inc_decode #(
        .PEND_W  (PEND_W),
        .BIG_STEP(BIG_STEP)
    ) u_dec (
        .ev_rx_err        (ev_rx_err),
        .ev_rx_dom_after  (ev_rx_dom_after),
        .ev_tx_err_flag   (ev_tx_err_flag),
        .tx_err_ack       (tx_err_ack),
        .tx_pflag_dom_seen(tx_pflag_dom_seen),
        .tx_err_stuff_arb (tx_err_stuff_arb),
        .ev_flag_bit_err  (ev_flag_bit_err),
        .node_is_tx       (node_is_tx),
        .passive_now      (passive_now),
        .run_hit          (run_hit),
        .run_tx           (run_tx),
        .tx_inc           (lane_add[FC_LANE_TX]),
        .rx_inc           (lane_add[FC_LANE_RX])
    );

    for (genvar g = 0; g < FC_LANES; g++) begin : g_lane
        can_fc_accum #(
            .PEND_W(PEND_W)
        ) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .commit(delim_start),
            .freeze(bus_off),
            .add   (lane_add[g]),
            .pend  (lane_pend[g])
        );
    end

    // Candidate values at commit time.
    always_comb begin
        tec_sum = SUM_W'(tec) + SUM_W'(lane_pend[FC_LANE_TX]);
        rec_sum = SUM_W'(rec) + SUM_W'(lane_pend[FC_LANE_RX]);
    end

    // Counter update: freeze, commit, or success decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tec         <= '0;
            rec         <= '0;
            rec_passive <= 1'b0;
            bus_off     <= 1'b0;
        end else if (bus_off) begin
            tec <= tec;
        end else if (delim_start) begin
            if (tec_sum > SUM_W'(TEC_MAX)) begin
                bus_off <= 1'b1;
                tec     <= TEC_W'(TEC_MAX);
            end else begin
                tec <= tec_sum[TEC_W-1:0];
            end
            if (!rec_passive) begin
                if (rec_sum > SUM_W'(REC_MAX)) begin
                    rec_passive <= 1'b1;
                    rec         <= REC_W'(REC_MAX);
                end else begin
                    rec <= rec_sum[REC_W-1:0];
                end
            end
        end else begin
            if (ev_tx_ok && (tec != '0)) tec <= tec - TEC_W'(1);
            if (ev_rx_ok) begin
                if (rec_passive) begin
                    rec         <= REC_W'(REC_RELOAD);
                    rec_passive <= 1'b0;
                end else if (rec != '0) begin
                    rec <= rec - REC_W'(1);
                end
            end
        end
    end

    // Overload request one cycle after an intermission bit error.
    always_ff @(posedge clk) begin
        if (!rst_n) overload_req <= 1'b0;
        else        overload_req <= intermission_err && !bus_off;
    end

    // Confinement state decode.
    always_comb begin
        err_passive = !bus_off && passive_now;
        err_active  = !bus_off && !passive_now;
    end

endmodule

// File: rtl/can_fc_counters_chk.sv
// Checker: temporal properties of the fault-confinement counters, bound
// to every instance of can_fc_counters.
module can_fc_counters_chk #(
    parameter int TEC_W      = 8,
    parameter int REC_W      = 7,
    parameter int REC_RELOAD = 127
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ev_tx_ok,
    input logic             ev_rx_ok,
    input logic             delim_start,
    input logic             intermission_err,
    input logic [TEC_W-1:0] tec,
    input logic [REC_W-1:0] rec,
    input logic             rec_passive,
    input logic             err_active,
    input logic             err_passive,
    input logic             bus_off,
    input logic             overload_req
);
    localparam int TEC_MAX = (1 << TEC_W) - 1;
    localparam int REC_MAX = (1 << REC_W) - 1;

    AST_TEC_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx_ok && !delim_start && !bus_off && tec != '0) |=> (tec == $past(tec) - TEC_W'(1))); // R7
    AST_TEC_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!delim_start && !ev_tx_ok) |=> $stable(tec)); // R6
    AST_REC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_ok && rec_passive && !delim_start && !bus_off) |=> (rec == REC_W'(REC_RELOAD) && !rec_passive)); // R8
    AST_REC_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        rec_passive |-> (rec == REC_W'(REC_MAX))); // R9
    AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({err_active, err_passive, bus_off}) == 1); // R10
    AST_BUSOFF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_off |=> (bus_off && $stable(tec) && $stable(rec))); // R11
    AST_BUSOFF_TEC: assert property (@(posedge clk) disable iff (!rst_n)
        bus_off |-> (tec == TEC_W'(TEC_MAX))); // R11
    AST_OVERLOAD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (intermission_err && !bus_off) |=> overload_req); // R12
    AST_OVERLOAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        overload_req |-> $past(intermission_err)); // R12

endmodule

bind can_fc_counters can_fc_counters_chk #(
    .TEC_W     (TEC_W),
    .REC_W     (REC_W),
    .REC_RELOAD(REC_RELOAD)
) u_chk (.*);

// File: tb/can_fc_counters_tb.sv
module can_fc_counters_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_rx_err = 0, ev_rx_dom_after = 0, ev_tx_err_flag = 0;
    logic tx_err_ack = 0, tx_pflag_dom_seen = 0, tx_err_stuff_arb = 0;
    logic ev_flag_bit_err = 0, node_is_tx = 0, flag_start = 0, flag_passive = 0;
    logic bit_strobe = 0, bit_dom = 0, ev_tx_ok = 0, ev_rx_ok = 0;
    logic delim_start = 0, intermission_err = 0;
    logic [7:0] tec;
    logic [6:0] rec;
    logic rec_passive, err_active, err_passive, bus_off, overload_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    can_fc_counters u_dut (.*);

    // Behavioural reference model
    int  m_tec, m_rec, m_ptec, m_prec, m_cnt, m_thr;
    bit  m_reps, m_boff, m_ovl, m_armed, m_rtx;

    always @(posedge clk) begin
        int ti, ri, nt, nr;
        bit hit, pas;
        if (!rst_n) begin
            m_tec = 0; m_rec = 0; m_ptec = 0; m_prec = 0; m_cnt = 0; m_thr = 14;
            m_reps = 0; m_boff = 0; m_ovl = 0; m_armed = 0; m_rtx = 0;
        end else begin
            hit = 0;
            pas = (m_tec > 127) || m_reps;
            if (flag_start) begin
                m_armed = 1; m_cnt = 0; m_thr = flag_passive ? 8 : 14; m_rtx = node_is_tx;
            end else if (delim_start) begin
                m_armed = 0;
            end else if (m_armed && bit_strobe) begin
                if (!bit_dom) m_armed = 0;
                else begin
                    m_cnt++;
                    if (m_cnt == m_thr) begin hit = 1; m_cnt = 0; m_thr = 8; end
                end
            end
            ti = 0; ri = 0;
            if (ev_tx_err_flag && !((tx_err_ack && pas && !tx_pflag_dom_seen) || tx_err_stuff_arb)) ti += 8;
            if (ev_flag_bit_err) begin if (node_is_tx) ti += 8; else ri += 8; end
            if (hit) begin if (m_rtx) ti += 8; else ri += 8; end
            if (ev_rx_err) ri += 1;
            if (ev_rx_dom_after) ri += 8;
            m_ovl = intermission_err && !m_boff;
            if (m_boff) begin
                m_ptec = 0; m_prec = 0;
            end else if (delim_start) begin
                nt = m_tec + m_ptec;
                nr = m_rec + m_prec;
                if (nt > 255) begin m_boff = 1; m_tec = 255; end else m_tec = nt;
                if (!m_reps) begin
                    if (nr > 127) begin m_reps = 1; m_rec = 127; end else m_rec = nr;
                end
                m_ptec = ti; m_prec = ri;
            end else begin
                if (ev_tx_ok && m_tec > 0) m_tec--;
                if (ev_rx_ok) begin
                    if (m_reps) begin m_rec = 127; m_reps = 0; end
                    else if (m_rec > 0) m_rec--;
                end
                m_ptec = (m_ptec + ti > 1023) ? 1023 : m_ptec + ti;
                m_prec = (m_prec + ri > 1023) ? 1023 : m_prec + ri;
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("model tec", tec, m_tec);
            chk("model rec", rec, m_rec);
            chk("model rec_passive", rec_passive, m_reps);
            chk("model bus_off", bus_off, m_boff);
            chk("model err_passive", err_passive, !m_boff && (m_tec > 127 || m_reps));
            chk("model err_active", err_active, !m_boff && !(m_tec > 127 || m_reps));
            chk("model overload_req", overload_req, m_ovl);
        end
    end

    task automatic cyc(); @(negedge clk); endtask
    task automatic rx_err();   ev_rx_err = 1; cyc(); ev_rx_err = 0; endtask
    task automatic rx_dom();   ev_rx_dom_after = 1; cyc(); ev_rx_dom_after = 0; endtask
    task automatic delim();    delim_start = 1; cyc(); delim_start = 0; endtask
    task automatic tx_ok();    ev_tx_ok = 1; cyc(); ev_tx_ok = 0; endtask
    task automatic rx_ok();    ev_rx_ok = 1; cyc(); ev_rx_ok = 0; endtask
    task automatic tx_flag(bit ack, bit pdom, bit stuff);
        ev_tx_err_flag = 1; tx_err_ack = ack; tx_pflag_dom_seen = pdom; tx_err_stuff_arb = stuff;
        cyc();
        ev_tx_err_flag = 0; tx_err_ack = 0; tx_pflag_dom_seen = 0; tx_err_stuff_arb = 0;
    endtask
    task automatic flag_bit_err(bit as_tx);
        node_is_tx = as_tx; ev_flag_bit_err = 1; cyc(); ev_flag_bit_err = 0;
    endtask
    task automatic start_run(bit as_tx, bit passive);
        node_is_tx = as_tx; flag_passive = passive; flag_start = 1; cyc(); flag_start = 0;
    endtask
    task automatic bits(int n, bit dom);
        for (int i = 0; i < n; i++) begin
            bit_strobe = 1; bit_dom = dom; cyc();
        end
        bit_strobe = 0; bit_dom = 0;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        chk("R1 tec", tec, 0); chk("R1 rec", rec, 0); chk("R1 reps", rec_passive, 0);
        chk("R1 active", err_active, 1); chk("R1 busoff", bus_off, 0); chk("R1 ovl", overload_req, 0);

        rx_ok(); chk("R8 rec zero hold", rec, 0);
        rx_err(); rx_err(); rx_err();
        chk("R6 rec before delimiter", rec, 0);
        delim(); chk("R2 rec +3", rec, 3);
        rx_dom(); delim(); chk("R2 rec +8", rec, 11); chk("R2 tec untouched", tec, 0);
        rx_ok(); chk("R8 rec -1", rec, 10);

        tx_flag(0, 0, 0); delim(); chk("R3 tec +8", tec, 8);
        tx_ok(); chk("R7 tec -1", tec, 7);
        for (int i = 0; i < 7; i++) tx_ok();
        chk("R7 tec at 0", tec, 0);
        tx_ok(); chk("R7 tec zero hold", tec, 0);
        tx_flag(0, 0, 1); delim(); chk("R3 stuff exemption", tec, 0);

        flag_bit_err(1); delim(); chk("R4 tx flag bit err", tec, 8);
        flag_bit_err(0); delim(); chk("R4 rx flag bit err", rec, 18);

        start_run(1, 0); bits(14, 1); bits(8, 1); bits(1, 0); delim();
        chk("R5 active run 14+8", tec, 24);
        start_run(0, 1); bits(8, 1); bits(1, 0); delim();
        chk("R5 passive run 8", rec, 26);
        start_run(1, 0); bits(13, 1); bits(1, 0); bits(3, 1); delim();
        chk("R5 short run no add", tec, 24);

        tx_flag(0, 0, 0); cyc();
        delim_start = 1; ev_tx_ok = 1; cyc(); delim_start = 0; ev_tx_ok = 0;
        chk("R13 commit wins over decrement", tec, 32);

        intermission_err = 1; cyc(); intermission_err = 0;
        chk("R12 overload pulse", overload_req, 1); chk("R12 no counter change", tec, 32);
        cyc(); chk("R12 pulse ends", overload_req, 0);

        for (int i = 0; i < 11; i++) begin tx_flag(0, 0, 0); delim(); end
        chk("R10 still active at 120", err_active, 1); chk("R10 tec 120", tec, 120);
        tx_flag(0, 0, 0); delim();
        chk("R10 passive at 128", err_passive, 1); chk("R10 not active", err_active, 0);

        tx_flag(1, 0, 0); delim(); chk("R3 ack passive exemption", tec, 128);
        tx_flag(1, 1, 0); delim(); chk("R3 ack with dominant seen", tec, 136);

        for (int i = 0; i < 12; i++) begin rx_dom(); delim(); end
        chk("R2 rec 122", rec, 122); chk("R9 reps clear", rec_passive, 0);
        rx_dom(); delim();
        chk("R9 rec capped", rec, 127); chk("R9 reps set", rec_passive, 1);
        rx_err(); delim(); chk("R9 ignored while passive", rec, 127);
        rx_ok(); chk("R8 reload", rec, 127); chk("R8 reps cleared", rec_passive, 0);
        rx_ok(); chk("R8 dec after reload", rec, 126);

        for (int i = 0; i < 14; i++) begin tx_flag(0, 0, 0); delim(); end
        chk("R11 tec 248", tec, 248); chk("R11 not yet off", bus_off, 0);
        tx_flag(0, 0, 0); delim();
        chk("R11 bus off", bus_off, 1); chk("R11 tec 255", tec, 255);
        chk("R10 not passive when off", err_passive, 0); chk("R10 not active when off", err_active, 0);
        rx_err(); tx_ok(); rx_ok(); delim();
        intermission_err = 1; cyc(); intermission_err = 0;
        chk("R11 tec frozen", tec, 255); chk("R11 rec frozen", rec, 126);
        chk("R11 overload suppressed", overload_req, 0);

        rst_n = 0; cyc(); cyc(); rst_n = 1; cyc();
        chk("R1 tec after reset", tec, 0); chk("R1 busoff after reset", bus_off, 0);
        chk("R1 active after reset", err_active, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule